// File: doc/BRIEF.md
# Enhanced PMP permission checker

This block decides whether one memory access may proceed under physical memory protection with the machine-mode lockdown and whitelist extensions. Address comparison happens elsewhere: for every protection entry the block receives two range-comparison hits (lower bound and upper bound) and the entry's 8-bit configuration byte. It picks the winning entry and turns that entry's lock and permission bits into an allowed permission mask. The mask depends on the privilege mode and on two security-policy bits, lockdown and whitelist. When no entry matches, a default policy applies. The block then grants the access only if every requested permission is in the allowed mask.

All outputs are pure combinational functions of the inputs, so the checker can sit directly in a fetch or load/store path. The number of entries is a parameter (default 16).

Top module: `epmp_perm_check`

## Requirements
- R1: Entry i counts as matched only when `rng_lo_hit[i]` and `rng_hi_hit[i]` are both 1 and the address-mode field (configuration bits 4:3) is non-zero. A zero mode means the entry is off and does not match.
- R2: When several entries match, only the lowest-numbered matching entry determines the allowed mask.
- R3: With `lockdown`=0 and a matching entry, the allowed mask is RWX in machine mode when the entry's lock bit (configuration bit 7) is 0. Otherwise the mask is the entry's own R, W, X bits (configuration bits 0, 1, 2). Masks here and on `req_perm`/`allow_perm` use bit 0 = read, bit 1 = write, bit 2 = execute.
- R4: With `lockdown`=1, a matching entry and machine mode, the mask comes from index {L,R,W,X} (L is bit 3, X is bit 0). Indices 0, 1, 4–8 give nothing. Indices 2, 3 and 14 give RW. Indices 9 and 10 give X. Indices 11 and 13 give RX. Indices 12 and 15 give R.
- R5: With `lockdown`=1, a matching entry and lower privilege, the same index gives the mask as follows. Indices 0, 8, 9, 12, 13 and 14 give nothing. Indices 1, 10 and 11 give X. Indices 2, 4 and 15 give R. Indices 3 and 6 give RW. Index 5 gives RX. Index 7 gives RWX.
- R6: With no matching entry and `whitelist`=1, the mask is 0 in every mode and regardless of `lockdown`.
- R7: With no matching entry, `whitelist`=0 and `lockdown`=1, a machine-mode request without execute gets mask RW. Every other request gets mask 0.
- R8: With no matching entry and both policy bits 0, machine mode gets RWX and lower privilege gets 0.
- R9: `grant` is 1 exactly when every bit set in `req_perm` is also set in `allow_perm`. An empty request is therefore granted.
- R10: `whitelist` has no effect on the result when an entry matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_m | input | 1 | 1 = machine mode, 0 = lower privilege |
| req_perm | input | 3 | Requested permissions (bit0 R, bit1 W, bit2 X) |
| rng_lo_hit | input | NUM_ENTRIES | Per-entry lower-bound comparison hit |
| rng_hi_hit | input | NUM_ENTRIES | Per-entry upper-bound comparison hit |
| entry_cfg | input | 8*NUM_ENTRIES | Configuration bytes, entry i in bits 8i+7:8i |
| lockdown | input | 1 | Machine-mode lockdown policy bit |
| whitelist | input | 1 | Default-deny whitelist policy bit |
| allow_perm | output | 3 | Allowed permission mask |
| grant | output | 1 | Access permitted |

## Verification
The bench sweeps all sixteen lock/permission indices in both privilege modes with lockdown set. A transposed row or a swapped bit in either table therefore shows up as a wrong mask or a wrong full-request grant. Directed cases cover the following mistakes:
- An entry that is turned off yet still matches, and one that matches on a single range hit. Either case would replace the default RWX with the entry's narrow mask.
- Two matching entries, where a design that lets the higher index win reports the wrong entry's bits.
- The default policies. A design that lets lockdown outrank whitelist would grant machine reads with no matching entry. A design that ignores the execute request under lockdown would grant a machine fetch.
- The empty request, which a design that checks for a non-zero overlap would deny.

// File: rtl/epmp_chk_pkg.sv
package epmp_chk_pkg;

   localparam int CFG_W  = 8;
   localparam int PERM_W = 3;
   localparam int IDX_W  = 4;

   typedef logic [PERM_W-1:0] perm_t;

   localparam perm_t PERM_NONE = 3'b000;
   localparam perm_t PERM_R    = 3'b001;
   localparam perm_t PERM_RW   = 3'b011;
   localparam perm_t PERM_X    = 3'b100;
   localparam perm_t PERM_RX   = 3'b101;
   localparam perm_t PERM_RWX  = 3'b111;

   typedef struct packed {
      logic       lock;
      logic [1:0] rsvd;
      logic [1:0] amode;
      logic       x;
      logic       w;
      logic       r;
   } entry_cfg_t;

   // machine mode under lockdown, index {L,R,W,X}
   function automatic perm_t lockdown_m_perm(input logic [IDX_W-1:0] idx);
      perm_t p;
      case (idx)
         4'd2, 4'd3, 4'd14: p = PERM_RW;
         4'd9, 4'd10:       p = PERM_X;
         4'd11, 4'd13:      p = PERM_RX;
         4'd12, 4'd15:      p = PERM_R;
         default:           p = PERM_NONE;
      endcase
      return p;
   endfunction

   // lower privilege under lockdown, index {L,R,W,X}
   function automatic perm_t lockdown_u_perm(input logic [IDX_W-1:0] idx);
      perm_t p;
      case (idx)
         4'd1, 4'd10, 4'd11: p = PERM_X;
         4'd2, 4'd4, 4'd15:  p = PERM_R;
         4'd3, 4'd6:         p = PERM_RW;
         4'd5:               p = PERM_RX;
         4'd7:               p = PERM_RWX;
         default:            p = PERM_NONE;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/epmp_first_hit.sv
module epmp_first_hit
   import epmp_chk_pkg::*;
#(
   parameter int NUM_ENTRIES = 16
) (
   input  logic [NUM_ENTRIES-1:0]       rng_lo_hit,
   input  logic [NUM_ENTRIES-1:0]       rng_hi_hit,
   input  logic [NUM_ENTRIES*CFG_W-1:0] entry_cfg,
   output logic                         any_hit,
   output logic [IDX_W-1:0]             sel_idx
);

   entry_cfg_t             ent [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] hit;
   logic [NUM_ENTRIES-1:0] first;
   logic [NUM_ENTRIES-1:0] unused_rsvd_bits;
   logic                   unused_rsvd;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      assign ent[i] = entry_cfg_t'(entry_cfg[i*CFG_W +: CFG_W]);
      assign hit[i] = rng_lo_hit[i] & rng_hi_hit[i] & (ent[i].amode != 2'b00);
      assign unused_rsvd_bits[i] = ^ent[i].rsvd;
   end
   assign unused_rsvd = ^unused_rsvd_bits;

   // lowest index wins
   always_comb begin
      logic found;
      found   = 1'b0;
      first   = '0;
      sel_idx = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (hit[i] && !found) begin
            first[i] = 1'b1;
            sel_idx  = {ent[i].lock, ent[i].r, ent[i].w, ent[i].x};
            found    = 1'b1;
         end
      end
      any_hit = found;
   end

   always_comb begin
      p_first_onehot_r2: assert ($onehot0(first))
         else $error("more than one winning entry");
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         p_first_is_match_r1: assert (!first[i] ||
            (rng_lo_hit[i] && rng_hi_hit[i] && entry_cfg[i*CFG_W+3 +: 2] != 2'b00))
            else $error("winner %0d is not a valid match", i);
      end
   end

endmodule

// File: rtl/epmp_entry_perm.sv
module epmp_entry_perm
   import epmp_chk_pkg::*;
(
   input  logic             priv_m,
   input  logic             lockdown,
   input  logic [IDX_W-1:0] idx,
   output perm_t            allow
);

   perm_t own_bits;
   assign own_bits = {idx[0], idx[1], idx[2]};

   always_comb begin
      if (!lockdown)
         allow = (priv_m && !idx[3]) ? PERM_RWX : own_bits;
      else if (priv_m)
         allow = lockdown_m_perm(idx);
      else
         allow = lockdown_u_perm(idx);
   end

   always_comb begin
      p_legacy_subset_r3: assert (lockdown || (priv_m && !idx[3]) ||
                                  ((allow & ~own_bits) == 3'b000))
         else $error("legacy mask exceeds entry bits");
      p_m_no_write_only_r4: assert (!(lockdown && priv_m) || !(allow[1] && !allow[0]))
         else $error("machine lockdown mask has W without R");
      p_u_full_only_idx7_r5: assert (!(lockdown && !priv_m && allow == PERM_RWX) ||
                                     idx == 4'd7)
         else $error("lower-mode RWX from index %0d", idx);
   end

endmodule

// File: rtl/epmp_default_perm.sv
module epmp_default_perm
   import epmp_chk_pkg::*;
(
   input  logic  priv_m,
   input  logic  lockdown,
   input  logic  whitelist,
   input  logic  req_x,
   output perm_t allow
);

   always_comb begin
      if (whitelist)
         allow = PERM_NONE;
      else if (lockdown)
         allow = (priv_m && !req_x) ? PERM_RW : PERM_NONE;
      else
         allow = priv_m ? PERM_RWX : PERM_NONE;
   end

endmodule

// File: rtl/epmp_perm_check.sv
module epmp_perm_check
   import epmp_chk_pkg::*;
#(
   parameter int NUM_ENTRIES = 16
) (
   input  logic                         priv_m,
   input  logic [2:0]                   req_perm,
   input  logic [NUM_ENTRIES-1:0]       rng_lo_hit,
   input  logic [NUM_ENTRIES-1:0]       rng_hi_hit,
   input  logic [NUM_ENTRIES*8-1:0]     entry_cfg,
   input  logic                         lockdown,
   input  logic                         whitelist,
   output logic [2:0]                   allow_perm,
   output logic                         grant
);

   localparam int CFG_BITS = NUM_ENTRIES * CFG_W;

   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64) begin : g_bad_entries
      $error("NUM_ENTRIES must lie in 1..64");
   end
   if (CFG_BITS != NUM_ENTRIES * 8) begin : g_bad_cfg
      $error("configuration byte width mismatch");
   end

   logic             any_hit;
   logic [IDX_W-1:0] sel_idx;
   perm_t            rule_allow;
   perm_t            dflt_allow;

   epmp_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) u_first (
      .rng_lo_hit (rng_lo_hit),
      .rng_hi_hit (rng_hi_hit),
      .entry_cfg  (entry_cfg),
      .any_hit    (any_hit),
      .sel_idx    (sel_idx)
   );

   epmp_entry_perm u_rule (
      .priv_m   (priv_m),
      .lockdown (lockdown),
      .idx      (sel_idx),
      .allow    (rule_allow)
   );

   epmp_default_perm u_dflt (
      .priv_m    (priv_m),
      .lockdown  (lockdown),
      .whitelist (whitelist),
      .req_x     (req_perm[2]),
      .allow     (dflt_allow)
   );

   assign allow_perm = any_hit ? rule_allow : dflt_allow;
   assign grant      = ((req_perm & allow_perm) == req_perm);

   always_comb begin
      p_grant_subset_r9: assert (!grant || ((req_perm & ~allow_perm) == 3'b000))
         else $error("grant with missing permission");
      p_whitelist_deny_r6: assert (any_hit || !whitelist || allow_perm == PERM_NONE)
         else $error("whitelist default not empty");
      p_lockdown_dflt_r7: assert (any_hit || whitelist || !lockdown ||
                                  allow_perm == ((priv_m && !req_perm[2]) ? PERM_RW : PERM_NONE))
         else $error("lockdown default wrong");
      p_open_dflt_r8: assert (any_hit || whitelist || lockdown ||
                              allow_perm == (priv_m ? PERM_RWX : PERM_NONE))
         else $error("open default wrong");
   end

endmodule

// File: tb/tb_epmp_perm_check.sv
`timescale 1ns/1ps
module tb_epmp_perm_check;

   localparam int N = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           priv_m;
   logic [2:0]     req_perm;
   logic [N-1:0]   rng_lo_hit, rng_hi_hit;
   logic [N*8-1:0] entry_cfg;
   logic           lockdown, whitelist;
   logic [2:0]     allow_perm;
   logic           grant;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   epmp_perm_check #(.NUM_ENTRIES(N)) dut (
      .priv_m(priv_m), .req_perm(req_perm),
      .rng_lo_hit(rng_lo_hit), .rng_hi_hit(rng_hi_hit),
      .entry_cfg(entry_cfg), .lockdown(lockdown), .whitelist(whitelist),
      .allow_perm(allow_perm), .grant(grant)
   );

   // {machine, idx[3:0], expected mask}: expectations of R4 (machine) and R5 (lower)
   localparam logic [7:0] TV [32] = '{
      {1'b1,4'd0 ,3'b000}, {1'b1,4'd1 ,3'b000}, {1'b1,4'd2 ,3'b011}, {1'b1,4'd3 ,3'b011},
      {1'b1,4'd4 ,3'b000}, {1'b1,4'd5 ,3'b000}, {1'b1,4'd6 ,3'b000}, {1'b1,4'd7 ,3'b000},
      {1'b1,4'd8 ,3'b000}, {1'b1,4'd9 ,3'b100}, {1'b1,4'd10,3'b100}, {1'b1,4'd11,3'b101},
      {1'b1,4'd12,3'b001}, {1'b1,4'd13,3'b101}, {1'b1,4'd14,3'b011}, {1'b1,4'd15,3'b001},
      {1'b0,4'd0 ,3'b000}, {1'b0,4'd1 ,3'b100}, {1'b0,4'd2 ,3'b001}, {1'b0,4'd3 ,3'b011},
      {1'b0,4'd4 ,3'b001}, {1'b0,4'd5 ,3'b101}, {1'b0,4'd6 ,3'b011}, {1'b0,4'd7 ,3'b111},
      {1'b0,4'd8 ,3'b000}, {1'b0,4'd9 ,3'b000}, {1'b0,4'd10,3'b100}, {1'b0,4'd11,3'b100},
      {1'b0,4'd12,3'b000}, {1'b0,4'd13,3'b000}, {1'b0,4'd14,3'b000}, {1'b0,4'd15,3'b001}
   };

   // cfg byte: bit7 lock, bits4:3 mode, bit2 X, bit1 W, bit0 R
   function automatic logic [7:0] mk_cfg(input logic l, input logic [1:0] am,
                                         input logic x, input logic w, input logic r);
      return {l, 2'b00, am, x, w, r};
   endfunction

   task automatic clear_entries();
      rng_lo_hit = '0;
      rng_hi_hit = '0;
      entry_cfg  = '0;
   endtask

   task automatic set_entry(input int i, input logic lo, input logic hi, input logic [7:0] c);
      rng_lo_hit[i]      = lo;
      rng_hi_hit[i]      = hi;
      entry_cfg[i*8 +: 8] = c;
   endtask

   task automatic chk(input string tag, input logic [2:0] exp_a, input logic exp_g);
      @(negedge clk);
      total++;
      if (allow_perm !== exp_a || grant !== exp_g) begin
         bad++;
         $display("FAIL %s: allow=%b grant=%b expected allow=%b grant=%b",
                  tag, allow_perm, grant, exp_a, exp_g);
      end
      @(posedge clk);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      priv_m = 1'b0; req_perm = 3'b000; lockdown = 1'b0; whitelist = 1'b0;
      clear_entries();
      repeat (2) @(posedge clk);
      rst_n = 1'b1;

      // idle state: lower mode, no match, read request (R8)
      req_perm = 3'b001;
      chk("R8 idle lower deny", 3'b000, 1'b0);

      // table sweep under lockdown; whitelist toggled (R10)
      for (int k = 0; k < 32; k++) begin
         logic [3:0] idx;
         idx = TV[k][6:3];
         clear_entries();
         set_entry(0, 1'b1, 1'b1, mk_cfg(idx[3], 2'b01, idx[0], idx[1], idx[2]));
         priv_m    = TV[k][7];
         lockdown  = 1'b1;
         whitelist = k[0];
         req_perm  = 3'b111;
         chk(TV[k][7] ? "R4 machine table full req" : "R5 lower table full req",
             TV[k][2:0], TV[k][2:0] == 3'b111);
         req_perm  = TV[k][2:0];
         chk("R10 table with whitelist, exact req", TV[k][2:0], 1'b1);
      end

      // R1: single-range hit does not match; off mode does not match
      lockdown = 1'b0; whitelist = 1'b0; priv_m = 1'b1; req_perm = 3'b111;
      clear_entries();
      set_entry(3, 1'b1, 1'b0, mk_cfg(1'b1, 2'b01, 1'b0, 1'b0, 1'b1));
      chk("R1 lo only no match", 3'b111, 1'b1);
      clear_entries();
      set_entry(3, 1'b1, 1'b1, mk_cfg(1'b1, 2'b00, 1'b0, 1'b0, 1'b1));
      chk("R1 mode off no match", 3'b111, 1'b1);
      clear_entries();
      set_entry(3, 1'b1, 1'b1, mk_cfg(1'b1, 2'b11, 1'b0, 1'b0, 1'b1));
      chk("R1 valid match locked R", 3'b001, 1'b0);

      // R2: lowest index wins
      priv_m = 1'b0; req_perm = 3'b101;
      clear_entries();
      set_entry(5, 1'b1, 1'b1, mk_cfg(1'b1, 2'b01, 1'b0, 1'b1, 1'b0));
      set_entry(2, 1'b1, 1'b1, mk_cfg(1'b1, 2'b01, 1'b1, 1'b0, 1'b1));
      chk("R2 lowest of two wins", 3'b101, 1'b1);
      clear_entries();
      set_entry(N-1, 1'b1, 1'b1, mk_cfg(1'b0, 2'b10, 1'b0, 1'b1, 1'b0));
      req_perm = 3'b010;
      chk("R2 last entry alone", 3'b010, 1'b1);

      // R3: legacy rule
      priv_m = 1'b1; req_perm = 3'b111;
      clear_entries();
      set_entry(1, 1'b1, 1'b1, mk_cfg(1'b0, 2'b01, 1'b0, 1'b0, 1'b1));
      chk("R3 machine unlocked RWX", 3'b111, 1'b1);
      set_entry(1, 1'b1, 1'b1, mk_cfg(1'b1, 2'b01, 1'b0, 1'b0, 1'b1));
      chk("R3 machine locked own bits", 3'b001, 1'b0);
      priv_m = 1'b0;
      set_entry(1, 1'b1, 1'b1, mk_cfg(1'b0, 2'b01, 1'b0, 1'b1, 1'b0));
      chk("R3 lower unlocked own bits", 3'b010, 1'b0);

      // R10: whitelist with a match, legacy mode
      whitelist = 1'b1; req_perm = 3'b010;
      set_entry(1, 1'b1, 1'b1, mk_cfg(1'b0, 2'b01, 1'b0, 1'b1, 1'b1));
      chk("R10 whitelist ignored on match", 3'b011, 1'b1);

      // R6: whitelist default deny
      clear_entries();
      priv_m = 1'b1; req_perm = 3'b001; lockdown = 1'b0;
      chk("R6 machine deny", 3'b000, 1'b0);
      lockdown = 1'b1;
      chk("R6 machine deny with lockdown", 3'b000, 1'b0);

      // R7: lockdown default
      whitelist = 1'b0; req_perm = 3'b011;
      chk("R7 machine RW granted", 3'b011, 1'b1);
      req_perm = 3'b100;
      chk("R7 machine fetch denied", 3'b000, 1'b0);
      req_perm = 3'b101;
      chk("R7 machine R+X denied", 3'b000, 1'b0);
      priv_m = 1'b0; req_perm = 3'b001;
      chk("R7 lower denied", 3'b000, 1'b0);

      // R8: open default
      lockdown = 1'b0; priv_m = 1'b1; req_perm = 3'b111;
      chk("R8 machine RWX", 3'b111, 1'b1);
      priv_m = 1'b0; req_perm = 3'b100;
      chk("R8 lower deny", 3'b000, 1'b0);

      // R9: partial and empty requests
      priv_m = 1'b0;
      set_entry(4, 1'b1, 1'b1, mk_cfg(1'b0, 2'b01, 1'b1, 1'b0, 1'b1));
      req_perm = 3'b011;
      chk("R9 partial overlap denied", 3'b101, 1'b0);
      req_perm = 3'b000;
      chk("R9 empty request granted", 3'b101, 1'b1);
      set_entry(4, 1'b1, 1'b1, mk_cfg(1'b0, 2'b01, 1'b0, 1'b0, 1'b0));
      chk("R9 empty request, empty mask", 3'b000, 1'b1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule